// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Slice

This block models one programmable logic slice. It has four lanes. Each lane holds a 64-bit truth table that acts as a 6-input lookup table. The same table can also be read as two 5-input functions, one from each 32-bit half, and both halves see the same five low inputs.

Behind each table sits a register with a clock enable and a set/reset. A per-lane select feeds that register either the table output or the lane's bypass input. The set/reset can be configured as synchronous or asynchronous. Alongside the lanes are two further structures:
- a 4-bit ripple carry chain, which uses the table outputs as propagate and the bypass inputs as generate, so the slice can form a 4-bit adder;
- a two-level wide multiplexer that merges pairs of table outputs into 7-input functions and the pair of those into an 8-input function.

All truth tables and per-lane control bits are loaded through a one-bit serial configuration port before normal operation begins. The reset input is active low. It asserts asynchronously and is released synchronously through an internal two-stage synchronizer.

Top module: `cfg_logic_slice`

## Requirements
- R1: While `cfg_en` is high, one bit of `cfg_din` is taken on every rising clock edge. After exactly 268 such bits, the first bit shifted in is configuration bit 0. Bit 64*k+i is bit i of lane k's truth table. Bits 256+3*k, 256+3*k+1 and 256+3*k+2 are lane k's asynchronous-mode flag, set/reset value and data select.
- R2: While `cfg_en` is low, the configuration does not change, whatever `cfg_din` does.
- R3: `fn6[k]` is the truth-table bit of lane k whose index is `lut_in[6k+5:6k]`. `lut_in[6k+5]` is the first-listed input and the most significant index bit. A table with only bit 3 set gives 1 for index 3 only.
- R4: `fn5_lo[k]` is table bit `lut_in[6k+4:6k]`, and `fn5_hi[k]` is table bit 32 + `lut_in[6k+4:6k]`.
- R5: With `sr[k]` low and `ce[k]` high, `q[k]` captures at the clock edge the bypass input `byp[k]` when the lane's data select is 1, and `fn6[k]` when it is 0.
- R6: When `sr[k]` and `ce[k]` are high together, set/reset wins. In synchronous mode, `q[k]` loads the configured set/reset value at the next edge and does not change before it.
- R7: In asynchronous mode, `q[k]` takes the configured set/reset value as soon as `sr[k]` rises, without a clock edge, and keeps it while `sr[k]` stays high.
- R8: With `sr[k]` and `ce[k]` both low, `q[k]` holds its value across clock edges.
- R9: Lane k's carry uses propagate `fn6[k]` and generate `byp[k]`. `sum[k]` = propagate XOR the lane's carry-in. The carry out is the incoming carry when propagate is 1, and generate when it is 0. `cin` enters lane 0 and `cout` leaves lane 3, so a lane table of in0 XOR in1 with bypass = in0 adds two 4-bit values.
- R10: `f7_out[j]` is `fn6[2j+1]` when `f7_sel[j]` is 1 and `fn6[2j]` otherwise. `f8_out` is `f7_out[1]` when `f8_sel` is 1 and `f7_out[0]` otherwise.
- R11: While `rst_n` is low, the configuration and all registers are zero at once. As a result, `fn6` and `q` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data |
| lut_in | input | 24 | Six table inputs per lane, lane k at [6k+5:6k] |
| byp | input | 4 | Per-lane bypass input (also the carry generate) |
| ce | input | 4 | Per-lane register clock enable |
| sr | input | 4 | Per-lane register set/reset |
| cin | input | 1 | Carry into lane 0 |
| f7_sel | input | 2 | Selects of the two 7-input merges |
| f8_sel | input | 1 | Select of the 8-input merge |
| fn6 | output | 4 | Combinational 6-input table outputs |
| fn5_hi | output | 4 | Upper-half 5-input outputs |
| fn5_lo | output | 4 | Lower-half 5-input outputs |
| sum | output | 4 | Carry-chain sum bits |
| cout | output | 1 | Carry out of lane 3 |
| f7_out | output | 2 | 7-input function outputs |
| f8_out | output | 1 | 8-input function output |
| q | output | 4 | Register outputs |

## Verification
The register assertions rely on the configuration staying steady while `sr` or `ce` is active, and on an asynchronous set/reset changing only away from the clock edge. The stimulus therefore finishes every configuration load with `cfg_en` low before it touches `ce` or `sr`, and it drives every input at the falling edge. The bench sweeps all 64 table indices on every lane together with all eight wide-mux select codes. It also sweeps all 512 combinations of the two 4-bit addends and the carry-in. Each expected value is computed from the tables and addends that the bench itself loaded.

// File: rtl/slice_pkg.sv
package slice_pkg;
  // per-lane control field, packed so async_mode is the lowest bit
  typedef struct packed {
    logic dsel;        // 1: bypass to register, 0: table output
    logic srval;       // value loaded by set/reset
    logic async_mode;  // 1: set/reset acts without the clock
  } lane_ctrl_t;

  localparam int CTRL_W = $bits(lane_ctrl_t);
endpackage

// File: rtl/slice_rst_sync.sv
module slice_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage0, stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage0 <= 1'b0;
      stage1 <= 1'b0;
    end else begin
      stage0 <= 1'b1;
      stage1 <= stage0;
    end
  end

  assign rst_sync_n = stage1;
endmodule

// File: rtl/slice_cfg_chain.sv
module slice_cfg_chain #(
  parameter int CFG_BITS = 268
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                shift_in,
  output logic [CFG_BITS-1:0] cfg
);
  logic [CFG_BITS-1:0] cfg_nxt;

  // new bits enter at the top, so the first bit ends up at index 0
  always_comb begin
    cfg_nxt = cfg;
    if (shift_en) cfg_nxt = {shift_in, cfg[CFG_BITS-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else        cfg <= cfg_nxt;
  end

  a_r1_shift_entry: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> cfg[CFG_BITS-1] == $past(shift_in));

  a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> cfg == $past(cfg));
endmodule

// File: rtl/slice_lut.sv
module slice_lut #(
  parameter int LUT_IN = 6,
  localparam int LUT_BITS = 1 << LUT_IN
) (
  input  logic [LUT_BITS-1:0] table_bits,
  input  logic [LUT_IN-1:0]   sel,
  output logic                out_full,
  output logic                out_hi,
  output logic                out_lo
);
  logic [LUT_IN-1:0] idx_hi, idx_lo;

  always_comb begin
    idx_hi   = {1'b1, sel[LUT_IN-2:0]};
    idx_lo   = {1'b0, sel[LUT_IN-2:0]};
    out_full = table_bits[sel];
    out_hi   = table_bits[idx_hi];
    out_lo   = table_bits[idx_lo];
  end
endmodule

// File: rtl/slice_carry.sv
module slice_carry #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] prop,
  input  logic [LANES-1:0] gen,
  input  logic             carry_in,
  output logic [LANES-1:0] sum,
  output logic             carry_out
);
  logic [LANES:0] chain;

  always_comb begin
    chain[0] = carry_in;
    for (int k = 0; k < LANES; k++) begin
      sum[k]      = prop[k] ^ chain[k];
      chain[k+1]  = prop[k] ? chain[k] : gen[k];
    end
    carry_out = chain[LANES];
  end
endmodule

// File: rtl/slice_lane_reg.sv
module slice_lane_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic sr,
  input  logic async_mode,
  input  logic srval,
  input  logic d,
  output logic q
);
  logic sr_async;
  logic q_nxt;

  assign sr_async = sr & async_mode;

  // set/reset has priority over the clock enable
  always_comb begin
    q_nxt = q;
    if (sr)      q_nxt = srval;
    else if (ce) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n or posedge sr_async) begin
    if (!rst_n)        q <= 1'b0;
    else if (sr_async) q <= srval;
    else               q <= q_nxt;
  end

  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr && ce && !async_mode) |=> q == $past(d));

  a_r6_sync_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (sr && !async_mode) |=> q == $past(srval));

  a_r7_async_level: assert property (@(posedge clk) disable iff (!rst_n)
    (sr && async_mode) |-> q == srval);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr && !ce && !async_mode) |=> q == $past(q));
endmodule

// File: rtl/cfg_logic_slice.sv
module cfg_logic_slice #(
  parameter int NUM_LANES = 4,
  parameter int LUT_IN    = 6,
  localparam int LUT_BITS  = 1 << LUT_IN,
  localparam int TBL_TOTAL = NUM_LANES * LUT_BITS,
  localparam int CFG_BITS  = NUM_LANES * (LUT_BITS + slice_pkg::CTRL_W),
  localparam int NUM_F7    = NUM_LANES / 2,
  localparam int NUM_F8    = NUM_LANES / 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_en,
  input  logic                        cfg_din,
  input  logic [NUM_LANES*LUT_IN-1:0] lut_in,
  input  logic [NUM_LANES-1:0]        byp,
  input  logic [NUM_LANES-1:0]        ce,
  input  logic [NUM_LANES-1:0]        sr,
  input  logic                        cin,
  input  logic [NUM_F7-1:0]           f7_sel,
  input  logic [NUM_F8-1:0]           f8_sel,
  output logic [NUM_LANES-1:0]        fn6,
  output logic [NUM_LANES-1:0]        fn5_hi,
  output logic [NUM_LANES-1:0]        fn5_lo,
  output logic [NUM_LANES-1:0]        sum,
  output logic                        cout,
  output logic [NUM_F7-1:0]           f7_out,
  output logic [NUM_F8-1:0]           f8_out,
  output logic [NUM_LANES-1:0]        q
);
  import slice_pkg::*;

  logic                rst_sync_n;
  logic [CFG_BITS-1:0] cfg;

  slice_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  slice_cfg_chain #(.CFG_BITS(CFG_BITS)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (cfg_en),
    .shift_in (cfg_din),
    .cfg      (cfg)
  );

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    lane_ctrl_t ctrl;
    logic       reg_d;

    assign ctrl  = lane_ctrl_t'(cfg[TBL_TOTAL + k*CTRL_W +: CTRL_W]);
    assign reg_d = ctrl.dsel ? byp[k] : fn6[k];

    slice_lut #(.LUT_IN(LUT_IN)) u_lut (
      .table_bits (cfg[k*LUT_BITS +: LUT_BITS]),
      .sel        (lut_in[k*LUT_IN +: LUT_IN]),
      .out_full   (fn6[k]),
      .out_hi     (fn5_hi[k]),
      .out_lo     (fn5_lo[k])
    );

    slice_lane_reg u_reg (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .ce         (ce[k]),
      .sr         (sr[k]),
      .async_mode (ctrl.async_mode),
      .srval      (ctrl.srval),
      .d          (reg_d),
      .q          (q[k])
    );
  end

  slice_carry #(.LANES(NUM_LANES)) u_carry (
    .prop      (fn6),
    .gen       (byp),
    .carry_in  (cin),
    .sum       (sum),
    .carry_out (cout)
  );

  // wide multiplexer tree: pairs of lanes, then pairs of pairs
  for (genvar j = 0; j < NUM_F7; j++) begin : g_f7
    assign f7_out[j] = f7_sel[j] ? fn6[2*j+1] : fn6[2*j];
  end
  for (genvar m = 0; m < NUM_F8; m++) begin : g_f8
    assign f8_out[m] = f8_sel[m] ? f7_out[2*m+1] : f7_out[2*m];
  end

  a_r9_full_propagate: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (&fn6) |-> cout == cin);

  a_r9_full_kill: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fn6 == '0 && byp == '0) |-> cout == 1'b0);

  a_r10_uniform_merge: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fn6 == '0 || fn6 == '1) |-> f8_out[0] == fn6[0]);

  a_r11_reset_clear: assert property (@(posedge clk)
    !rst_sync_n |-> q == '0);
endmodule

// File: tb/sim_cfg_logic_slice.sv
module sim_cfg_logic_slice;
  localparam int CLK_PERIOD = 10;
  localparam int NL   = 4;
  localparam int LI   = 6;
  localparam int CFGW = NL * (64 + 3);

  logic clk, rst_n, cfg_en, cfg_din, cin;
  logic [NL*LI-1:0] lut_in;
  logic [NL-1:0] byp, ce, sr, fn6, fn5_hi, fn5_lo, sum, q;
  logic [1:0] f7_sel, f7_out;
  logic [0:0] f8_sel, f8_out;
  logic cout;

  int n_cmp = 0;
  int n_bad = 0;
  logic [63:0] tt [NL];

  cfg_logic_slice #(.NUM_LANES(NL), .LUT_IN(LI)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .lut_in(lut_in), .byp(byp), .ce(ce), .sr(sr), .cin(cin),
    .f7_sel(f7_sel), .f8_sel(f8_sel), .fn6(fn6), .fn5_hi(fn5_hi),
    .fn5_lo(fn5_lo), .sum(sum), .cout(cout), .f7_out(f7_out),
    .f8_out(f8_out), .q(q)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_cfg(input logic [11:0] ctl);
    logic [CFGW-1:0] v;
    v = {ctl, tt[3], tt[2], tt[1], tt[0]};
    for (int i = 0; i < CFGW; i++) begin
      @(negedge clk);
      cfg_en  = 1'b1;
      cfg_din = v[i];
    end
    @(negedge clk);
    cfg_en  = 1'b0;
    cfg_din = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [3:0] qe;
    rst_n = 1'b0; cfg_en = 1'b0; cfg_din = 1'b0; cin = 1'b0;
    lut_in = '1; byp = '0; ce = '0; sr = '0; f7_sel = '0; f8_sel = '0;
    repeat (3) @(negedge clk);
    chk("R11 q in reset", q, 0);
    chk("R11 fn6 in reset", fn6, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 q after release", q, 0);

    // table sweep over all indices with wide-mux selects
    tt[0] = 64'hDEADBEEF01234567; tt[1] = 64'h0F0F00FF3C3CA5A5;
    tt[2] = 64'h8000000000000001; tt[3] = 64'h7FFFFFFFFFFFFFFE;
    load_cfg(12'h000);
    for (int idx = 0; idx < 64; idx++) begin
      logic [3:0] e;
      logic e70, e71;
      @(negedge clk);
      lut_in = {4{idx[5:0]}};
      #1;
      for (int k = 0; k < NL; k++) begin
        e[k] = tt[k][idx];
        chk("R1 R3 fn6", fn6[k], tt[k][idx]);
        chk("R4 fn5_lo", fn5_lo[k], tt[k][idx % 32]);
        chk("R4 fn5_hi", fn5_hi[k], tt[k][32 + idx % 32]);
      end
      for (int s = 0; s < 8; s++) begin
        f7_sel = s[1:0]; f8_sel = s[2:2];
        #0.5;
        e70 = s[0] ? e[1] : e[0];
        e71 = s[1] ? e[3] : e[2];
        chk("R10 f7", f7_out, {e71, e70});
        chk("R10 f8", f8_out, s[2] ? e71 : e70);
      end
    end

    // configuration frozen while cfg_en is low
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cfg_din = i[0];
    end
    for (int idx = 0; idx < 64; idx++) begin
      @(negedge clk);
      lut_in = {4{idx[5:0]}};
      #1;
      for (int k = 0; k < NL; k++) chk("R2 frozen table", fn6[k], tt[k][idx]);
    end

    // single-bit table: index 3 only, first-listed input is the MSB
    tt[0] = 64'h8; tt[1] = '0; tt[2] = '0; tt[3] = '0;
    load_cfg(12'h000);
    for (int idx = 0; idx < 64; idx++) begin
      @(negedge clk);
      lut_in = {18'b0, idx[5:0]};
      #1;
      chk("R3 bit3 table", fn6[0], idx == 3);
    end

    // 4-bit adder: table = in0 ^ in1, bypass = in0
    for (int k = 0; k < NL; k++) tt[k] = 64'h6666666666666666;
    load_cfg(12'h000);
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 2; c++) begin
          logic [4:0] s;
          @(negedge clk);
          for (int k = 0; k < NL; k++) lut_in[k*LI +: LI] = {4'b0, b[k], a[k]};
          byp = a[3:0];
          cin = c[0];
          #1;
          s = 5'(a) + 5'(b) + 5'(c);
          chk("R9 sum", sum, s[3:0]);
          chk("R9 cout", cout, s[4]);
        end
    cin = 1'b0;

    // registers: tables pass in0; lanes {dsel,srval,async}:
    // lane0 010, lane1 100, lane2 111, lane3 001
    for (int k = 0; k < NL; k++) tt[k] = 64'hAAAAAAAAAAAAAAAA;
    load_cfg(12'b001_111_100_010);
    lut_in = '0; byp = '0;
    for (int v = 0; v < 16; v++) begin
      for (int k = 0; k < NL; k++) lut_in[k*LI] = v[k];
      byp = ~v[3:0];
      ce = 4'hF; sr = 4'h0;
      @(negedge clk);
      qe = {v[3], ~v[2], ~v[1], v[0]};
      chk("R5 capture", q, qe);
    end
    ce = 4'h0;
    for (int i = 0; i < 3; i++) begin
      for (int k = 0; k < NL; k++) lut_in[k*LI] = ~qe[k];
      byp = ~byp;
      @(negedge clk);
      chk("R8 hold", q, qe);
    end

    // known state 1010: lane0 in0=0, lane1 byp=1, lane2 byp=0, lane3 in0=1
    lut_in[0] = 1'b0; lut_in[3*LI] = 1'b1; byp = 4'b0010; ce = 4'hF;
    @(negedge clk);
    chk("R5 setup", q, 4'b1010);
    sr = 4'b0011;
    #1;
    chk("R6 no effect before edge", q, 4'b1010);
    @(negedge clk);
    chk("R6 sync set/reset wins", q, 4'b1001);

    // restore 1010 then async set/reset on lanes 2 and 3
    sr = 4'b0000;
    @(negedge clk);
    chk("R5 restore", q, 4'b1010);
    ce = 4'h0; sr = 4'b1100;
    #1;
    chk("R7 async without edge", q, 4'b0110);
    ce = 4'hF;
    @(negedge clk);
    chk("R7 async held, wins over ce", q[3:2], 2'b01);
    sr = 4'b0000;
    @(negedge clk);
    chk("R5 after release", q, 4'b1010);

    // asynchronous reset clears configuration and registers
    ce = 4'h0; lut_in = '1;
    rst_n = 1'b0;
    #1;
    chk("R11 async clear q", q, 0);
    chk("R11 async clear cfg", fn6, 0);
    finish_run();
  end
endmodule